// File: doc/BRIEF.md
# Snooping Invalidate Coherence Controller

This block keeps one processor's small direct-mapped cache coherent with the other caches on a shared snooping bus. Every line holds one of three states: invalid, shared (a clean copy that other caches may also hold) or exclusive (the only copy, writable and possibly dirty). The processor side offers a read or write request with an address and data. The block either completes the request in the same cycle from the local arrays or holds it with a stall while it runs bus transactions. The tag, data and state arrays are part of the block.

On the bus side the controller requests the bus, waits for a grant and then drives one of three commands: read miss, write miss or write-back. After a miss it waits for a fill word. At the same time it watches the read and write misses that other caches put on the bus. When it holds the addressed line exclusive, it hands the block to the bus and raises a flag that tells memory to stay silent. It then downgrades or invalidates its own copy. A write to a line held shared is sent as an ordinary write miss, with no separate upgrade message. A line held exclusive is always written back before a new miss for another address that maps to the same line is sent. The bus is held from a miss grant until its fill, so bus order alone sets the order of all writes.

Top module: `snoop_coh_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address stalls and requests a read miss.
- R2: A read whose tag matches a shared or exclusive line completes in the cycle it is presented (stall low), returns the line's word and leaves the bus idle and the line state unchanged.
- R3: A read that misses, whether the line is invalid or shared with another tag, requests the bus with command 01 (read miss) and the request address, and no write-back comes before it. The fill word then installs the line as shared, and the read completes one cycle after the fill.
- R4: A miss that replaces a line held exclusive with another tag first requests command 11 (write-back) with the old line's address (old tag above the index) and its data. The line becomes invalid at that grant, and only then is the miss requested.
- R5: A write whose tag matches an exclusive line completes at once, updates the word and uses no bus transaction.
- R6: A write to a line that is invalid, shared or held under another tag requests command 10 (write miss). After the fill the line is exclusive and holds the written word, whatever the fill carried.
- R7: A snooped command 01 that hits a shared line has no effect. If it hits an exclusive line, the block raises the supply flag, drives the line's word and makes the line shared, all in that same cycle.
- R8: A snooped command 10 that hits a line invalidates it. If the line was exclusive, the block also raises the supply flag and drives the word in that cycle.
- R9: In any cycle in which the snoop command is 01 or 10, a pending processor request is stalled.
- R10: The stall is low whenever there is no request. The bus request stays high from a miss until the grant, and the bus command reads 00 whenever the bus is not being requested. The address split is: index = low log2(lines) address bits, tag = the remaining upper bits.
- R11: A snooped command 11 (write-back), or a snoop whose tag does not match the indexed line, changes no state and raises no supply flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, held until a cycle with stall low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when a read completes |
| cpu_stall | output | 1 | Request is held this cycle |
| bus_req | output | 1 | Bus wanted for the command on bus_cmd |
| bus_gnt | input | 1 | Grant; the command is taken in a cycle with bus_req and bus_gnt high |
| bus_cmd | output | 2 | 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Address of the outgoing command |
| bus_wdata | output | DATA_W | Block data of a write-back |
| fill_valid | input | 1 | Fill word for the pending miss is present |
| fill_data | input | DATA_W | Fill word |
| snp_cmd | input | 2 | Command of another cache seen on the bus, same encoding |
| snp_addr | input | ADDR_W | Address of the snooped command |
| snp_supply | output | 1 | This cache supplies the block; memory must not respond |
| snp_data | output | DATA_W | Block data supplied to the bus |

## Verification
The hardest situation to reach is a snoop that lands while a local miss is still waiting for its grant. Here the victim line the controller is about to write back can be downgraded or invalidated underneath it. The outgoing command must then switch from write-back to a plain miss without any stale data reaching the bus. The stimulus gets there in a random phase. Requests use a few tags over three indices, so replacements of exclusive lines are frequent. While a request is stalled, snoops to the same small address set are injected at random, and the grant is withheld at random so the requesting window stays open for several cycles.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE   = 2'b00,
        BC_RDMISS = 2'b01,
        BC_WRMISS = 2'b10,
        BC_WBACK  = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store #(
    parameter int LINES  = 8,
    parameter int IDX_W  = $clog2(LINES),
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32,
    parameter int NRD    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             upd_en,
    input  logic [IDX_W-1:0]                 upd_idx,
    input  logic [TAG_W-1:0]                 upd_tag,
    input  logic [DATA_W-1:0]                upd_data,
    input  logic [1:0]                       upd_st,
    input  logic                             snp_en,
    input  logic [IDX_W-1:0]                 snp_idx,
    input  logic [1:0]                       snp_st,
    input  logic [NRD-1:0][IDX_W-1:0]        rd_idx,
    output logic [NRD-1:0][TAG_W-1:0]        rd_tag,
    output logic [NRD-1:0][DATA_W-1:0]       rd_data,
    output logic [NRD-1:0][1:0]              rd_st
);

    typedef struct packed {
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] data;
        logic [LINES-1:0][1:0]        st;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (upd_en) begin
            s_d.tag[upd_idx]  = upd_tag;
            s_d.data[upd_idx] = upd_data;
            s_d.st[upd_idx]   = upd_st;
        end
        // a snoop state change wins over a local update to the same line
        if (snp_en) begin
            s_d.st[snp_idx] = snp_st;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_tag[p]  = s_q.tag[rd_idx[p]];
        assign rd_data[p] = s_q.data[rd_idx[p]];
        assign rd_st[p]   = s_q.st[rd_idx[p]];
    end

endmodule

// File: rtl/coh_probe.sv
module coh_probe #(
    parameter int TAG_W = 13
) (
    input  logic [TAG_W-1:0] ref_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [1:0]       line_st,
    output logic             hit,
    output logic             owned
);

    always_comb begin
        hit   = (line_st != coh_pkg::LN_INV) && (line_tag == ref_tag);
        owned = (line_st == coh_pkg::LN_EXC);
    end

endmodule

// File: rtl/snoop_coh_cache.sv
module snoop_coh_cache
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int NPORT = 2;   // port 0: processor lookup, port 1: snoop lookup

    typedef struct packed {
        phase_e phase;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NPORT-1:0][ADDR_W-1:0] look_addr;
    logic [NPORT-1:0][IDX_W-1:0]  rd_idx;
    logic [NPORT-1:0][TAG_W-1:0]  rd_tag;
    logic [NPORT-1:0][DATA_W-1:0] rd_data;
    logic [NPORT-1:0][1:0]        rd_st;
    logic [NPORT-1:0]             hit;
    logic [NPORT-1:0]             owned;

    logic              upd_en;
    logic [TAG_W-1:0]  upd_tag;
    logic [DATA_W-1:0] upd_data;
    logic [1:0]        upd_st;
    logic              snp_en;
    logic [1:0]        snp_st;

    logic              snp_act;
    logic              cpu_ok;
    logic              victim_wb;
    logic [TAG_W-1:0]  cpu_tag;

    assign look_addr[0] = cpu_addr;
    assign look_addr[1] = snp_addr;
    assign cpu_tag      = cpu_addr[ADDR_W-1:IDX_W];

    for (genvar p = 0; p < NPORT; p++) begin : g_look
        assign rd_idx[p] = look_addr[p][IDX_W-1:0];
        coh_probe #(.TAG_W(TAG_W)) probe_i (
            .ref_tag  (look_addr[p][ADDR_W-1:IDX_W]),
            .line_tag (rd_tag[p]),
            .line_st  (rd_st[p]),
            .hit      (hit[p]),
            .owned    (owned[p])
        );
    end

    coh_line_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W),
        .NRD   (NPORT)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .upd_idx (rd_idx[0]),
        .upd_tag (upd_tag),
        .upd_data(upd_data),
        .upd_st  (upd_st),
        .snp_en  (snp_en),
        .snp_idx (rd_idx[1]),
        .snp_st  (snp_st),
        .rd_idx  (rd_idx),
        .rd_tag  (rd_tag),
        .rd_data (rd_data),
        .rd_st   (rd_st)
    );

    assign cpu_rdata = rd_data[0];
    assign snp_data  = rd_data[1];

    always_comb begin
        c_d        = c_q;
        upd_en     = 1'b0;
        upd_tag    = rd_tag[0];
        upd_data   = rd_data[0];
        upd_st     = LN_INV;
        snp_en     = 1'b0;
        snp_st     = LN_INV;
        snp_supply = 1'b0;
        bus_req    = 1'b0;
        bus_cmd    = BC_IDLE;
        bus_addr   = cpu_addr;
        bus_wdata  = rd_data[0];
        cpu_stall  = cpu_req;

        snp_act   = (snp_cmd == BC_RDMISS) || (snp_cmd == BC_WRMISS);
        cpu_ok    = hit[0] && (!cpu_we || owned[0]);
        victim_wb = owned[0] && (rd_tag[0] != cpu_tag);

        // snooped traffic from other caches
        if (snp_act && hit[1]) begin
            if (snp_cmd == BC_RDMISS) begin
                if (owned[1]) begin
                    snp_supply = 1'b1;
                    snp_en     = 1'b1;
                    snp_st     = LN_SHR;
                end
            end else begin
                snp_supply = owned[1];
                snp_en     = 1'b1;
                snp_st     = LN_INV;
            end
        end

        // local request sequencing
        unique case (c_q.phase)
            PH_IDLE: begin
                if (cpu_req && !snp_act) begin
                    if (cpu_ok) begin
                        cpu_stall = 1'b0;
                        if (cpu_we) begin
                            upd_en   = 1'b1;
                            upd_data = cpu_wdata;
                            upd_st   = LN_EXC;
                        end
                    end else begin
                        c_d.phase = PH_REQ;
                    end
                end
            end
            PH_REQ: begin
                bus_req = 1'b1;
                if (victim_wb) begin
                    bus_cmd  = BC_WBACK;
                    bus_addr = {rd_tag[0], rd_idx[0]};
                    if (bus_gnt) begin
                        upd_en = 1'b1;
                        upd_st = LN_INV;
                    end
                end else begin
                    bus_cmd = cpu_we ? BC_WRMISS : BC_RDMISS;
                    if (bus_gnt) begin
                        c_d.phase = PH_WAIT;
                    end
                end
            end
            PH_WAIT: begin
                if (fill_valid) begin
                    upd_en    = 1'b1;
                    upd_tag   = cpu_tag;
                    upd_data  = cpu_we ? cpu_wdata : fill_data;
                    upd_st    = cpu_we ? LN_EXC : LN_SHR;
                    c_d.phase = PH_IDLE;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.phase <= PH_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_stall,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_supply
);

    assert_snoop_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && (snp_cmd == 2'b01 || snp_cmd == 2'b10)) |-> cpu_stall);

    assert_nostall_noreq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !cpu_stall);

    assert_idle_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_cmd == 2'b00));

    assert_req_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != 2'b00));

    assert_supply_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_cmd == 2'b01 || snp_cmd == 2'b10));

    assert_inv_after_wsnoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_supply && snp_cmd == 2'b10) |=> !(snp_supply && snp_addr == $past(snp_addr)));

    assert_wb_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'b11) |=> !(bus_cmd == 2'b11 && bus_addr == $past(bus_addr)));

endmodule

bind snoop_coh_cache coh_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_stall (cpu_stall),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .snp_cmd   (snp_cmd),
    .snp_addr  (snp_addr),
    .snp_supply(snp_supply)
);

// File: tb/snoop_coh_cache_tb_top.sv
`timescale 1ns/1ps
module snoop_coh_cache_tb_top;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LINES  = 8;
    localparam int LIMIT  = 20000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_req, cpu_we;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_wdata;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_stall;
    logic              bus_req, bus_gnt;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              fill_valid;
    logic [DATA_W-1:0] fill_data;
    logic [1:0]        snp_cmd;
    logic [ADDR_W-1:0] snp_addr;
    logic              snp_supply;
    logic [DATA_W-1:0] snp_data;

    always #2.5 clk = ~clk;

    snoop_coh_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .fill_valid(fill_valid), .fill_data(fill_data),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_supply(snp_supply), .snp_data(snp_data)
    );

    // reference model: line states 0 invalid, 1 shared, 2 exclusive
    int          m_st [LINES];
    int          m_tag[LINES];
    logic [31:0] m_dat[LINES];
    logic [31:0] mem[int];
    int          mph;        // 0 idle, 1 requesting bus, 2 waiting for fill
    int          wcnt;
    int          pend_addr;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int          kind;   // 0 cpu op, 1 snoop, 2 start random phase
        int          we;
        int          addr;
        logic [31:0] data;
    } op_t;
    op_t ops[$];

    function automatic logic [31:0] memval(int a);
        if (mem.exists(a)) return mem[a];
        return 32'hA500_0000 ^ a;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic add_cpu(int we, int addr, logic [31:0] d);
        op_t o;
        o.kind = 0; o.we = we; o.addr = addr; o.data = d;
        ops.push_back(o);
    endtask

    task automatic add_snp(int cmd, int addr);
        op_t o;
        o.kind = 1; o.we = cmd; o.addr = addr; o.data = '0;
        ops.push_back(o);
    endtask

    bit exp_stall;

    task automatic compare();
        int  ci, ct, si, st;
        bit  sact, ok, wb, shit;
        int  ecmd, eaddr;
        string rs;
        ci   = int'(cpu_addr) & (LINES - 1);
        ct   = int'(cpu_addr) >> 3;
        si   = int'(snp_addr) & (LINES - 1);
        st   = int'(snp_addr) >> 3;
        sact = (snp_cmd == 2'b01) || (snp_cmd == 2'b10);
        ok   = (m_st[ci] != 0) && (m_tag[ci] == ct) && (!cpu_we || m_st[ci] == 2);
        wb   = (m_st[ci] == 2) && (m_tag[ci] != ct);

        exp_stall = cpu_req && (sact || mph != 0 || !ok);
        if (sact && cpu_req)             rs = "R9";
        else if (!cpu_req || mph != 0)   rs = "R10";
        else if (cpu_we && ok)           rs = "R5";
        else                             rs = "R2";
        chk(cpu_stall == exp_stall, rs, "cpu_stall", 32'(cpu_stall), 32'(exp_stall));

        if (cpu_req && !cpu_we && !exp_stall)
            chk(cpu_rdata == m_dat[ci], "R2", "cpu_rdata", cpu_rdata, m_dat[ci]);

        ecmd  = 0;
        eaddr = int'(cpu_addr);
        if (mph == 1) begin
            if (wb) begin
                ecmd  = 3;
                eaddr = (m_tag[ci] << 3) | ci;
            end else begin
                ecmd = cpu_we ? 2 : 1;
            end
        end
        rs = (ecmd == 3) ? "R4" : (ecmd == 1) ? "R3" : (ecmd == 2) ? "R6" : "R10";
        chk(bus_req == (mph == 1), "R10", "bus_req", 32'(bus_req), 32'(mph == 1));
        chk(int'(bus_cmd) == ecmd, rs, "bus_cmd", 32'(bus_cmd), 32'(ecmd));
        if (ecmd != 0)
            chk(int'(bus_addr) == eaddr, rs, "bus_addr", 32'(bus_addr), 32'(eaddr));
        if (ecmd == 3)
            chk(bus_wdata == m_dat[ci], "R4", "bus_wdata", bus_wdata, m_dat[ci]);

        shit = sact && (m_st[si] == 2) && (m_tag[si] == st);
        rs   = (snp_cmd == 2'b01) ? "R7" : (snp_cmd == 2'b10) ? "R8" : "R11";
        chk(snp_supply == shit, rs, "snp_supply", 32'(snp_supply), 32'(shit));
        if (shit)
            chk(snp_data == m_dat[si], rs, "snp_data", snp_data, m_dat[si]);
    endtask

    task automatic model_step();
        int ci, ct, si, st;
        bit sact, ok, wb;
        ci   = int'(cpu_addr) & (LINES - 1);
        ct   = int'(cpu_addr) >> 3;
        si   = int'(snp_addr) & (LINES - 1);
        st   = int'(snp_addr) >> 3;
        sact = (snp_cmd == 2'b01) || (snp_cmd == 2'b10);
        ok   = (m_st[ci] != 0) && (m_tag[ci] == ct) && (!cpu_we || m_st[ci] == 2);
        wb   = (m_st[ci] == 2) && (m_tag[ci] != ct);

        if (mph == 0) begin
            if (cpu_req && !sact) begin
                if (ok && cpu_we) m_dat[ci] = cpu_wdata;
                else if (!ok)     mph = 1;
            end
        end else if (mph == 1) begin
            if (bus_gnt) begin
                if (wb) begin
                    mem[(m_tag[ci] << 3) | ci] = m_dat[ci];
                    m_st[ci] = 0;
                end else begin
                    pend_addr = int'(cpu_addr);
                    wcnt = 0;
                    mph  = 2;
                end
            end
        end else begin
            if (fill_valid) begin
                m_tag[ci] = ct;
                m_dat[ci] = cpu_we ? cpu_wdata : fill_data;
                m_st[ci]  = cpu_we ? 2 : 1;
                mph = 0;
            end else begin
                wcnt++;
            end
        end

        if (sact && m_st[si] != 0 && m_tag[si] == st) begin
            if (m_st[si] == 2) mem[int'(snp_addr)] = m_dat[si];
            if (snp_cmd == 2'b01) begin
                if (m_st[si] == 2) m_st[si] = 1;
            end else begin
                m_st[si] = 0;
            end
        end
    endtask

    initial begin
        int  cyc;
        bit  done_prev;
        bit  rnd_mode;
        bit  snp_now;
        op_t o;

        for (int i = 0; i < LINES; i++) begin
            m_st[i] = 0; m_tag[i] = 0; m_dat[i] = '0;
        end
        mph = 0; wcnt = 0; pend_addr = 0;
        rst_n = 1'b0;
        cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        bus_gnt = 0; fill_valid = 0; fill_data = '0;
        snp_cmd = 2'b00; snp_addr = '0;

        repeat (3) @(negedge clk);
        #1;
        // R1: reset leaves the bus and snoop outputs quiet
        chk(bus_req == 1'b0, "R1", "bus_req in reset", 32'(bus_req), 0);
        chk(bus_cmd == 2'b00, "R1", "bus_cmd in reset", 32'(bus_cmd), 0);
        chk(snp_supply == 1'b0, "R1", "snp_supply in reset", 32'(snp_supply), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed sequence
        add_cpu(0, 16'h0003, 0);            // R1/R3: first read misses
        add_cpu(0, 16'h0003, 0);            // R2: read hit shared
        add_cpu(1, 16'h0003, 32'h1111_0003); // R6: write to shared -> write miss
        add_cpu(1, 16'h0003, 32'h2222_0003); // R5: write hit exclusive
        add_cpu(0, 16'h0003, 0);            // R2: read hit exclusive
        add_cpu(0, 16'h000B, 0);            // R4: evict exclusive, write-back first
        add_cpu(0, 16'h0013, 0);            // R3: conflict with shared, no write-back
        add_cpu(0, 16'h0003, 0);            // R3: reload, memory now holds written data
        add_cpu(1, 16'h0005, 32'h3333_0005); // R6: write to invalid
        add_snp(1, 16'h0005);               // R7: supply, go shared
        add_snp(1, 16'h0005);               // R7: shared, no action
        add_cpu(1, 16'h0005, 32'h4444_0005); // R6: write on shared -> write miss
        add_snp(2, 16'h0005);               // R8: exclusive -> supply, invalid
        add_cpu(0, 16'h0005, 0);            // R8: line now misses
        add_snp(2, 16'h0005);               // R8: shared -> invalid, no supply
        add_cpu(0, 16'h0005, 0);
        add_snp(3, 16'h0005);               // R11: write-back snoop ignored
        add_snp(2, 16'h000D);               // R11: tag mismatch ignored
        add_cpu(0, 16'h0005, 0);            // R11: still a hit
        begin
            op_t m;
            m.kind = 2; m.we = 0; m.addr = 0; m.data = '0;
            ops.push_back(m);
        end
        for (int k = 0; k < 600; k++) begin
            int a;
            a = (($urandom % 4) << 3) | ($urandom % 3);
            if ($urandom % 5 == 0) add_snp(1 + ($urandom % 3), a);
            else add_cpu($urandom % 2, a, $urandom);
        end

        cyc = 0;
        done_prev = 0;
        rnd_mode = 0;
        while ((ops.size() > 0 || cpu_req) && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            if (done_prev) cpu_req = 0;
            snp_cmd = 2'b00;
            snp_now = 0;
            if (!cpu_req && ops.size() > 0) begin
                o = ops.pop_front();
                if (o.kind == 0) begin
                    cpu_req = 1; cpu_we = o.we[0];
                    cpu_addr = ADDR_W'(o.addr); cpu_wdata = o.data;
                end else if (o.kind == 1) begin
                    snp_cmd = 2'(o.we); snp_addr = ADDR_W'(o.addr);
                    snp_now = 1;
                end else begin
                    rnd_mode = 1;
                end
            end else if (cpu_req && rnd_mode && mph != 2 && ($urandom % 3 == 0)) begin
                snp_cmd  = 2'(1 + ($urandom % 3));
                snp_addr = ADDR_W'((($urandom % 4) << 3) | ($urandom % 3));
                snp_now  = 1;
            end
            bus_gnt    = (mph == 1) && !snp_now && ($urandom % 2 == 0);
            fill_valid = (mph == 2) && (wcnt >= 2);
            fill_data  = memval(pend_addr);
            #1;
            compare();
            @(posedge clk);
            done_prev = cpu_req && !exp_stall;
            model_step();
        end

        if (cyc >= LIMIT) begin
            fails++;
            $display("FAIL watchdog R10 actual=%0d expected<%0d", cyc, LIMIT);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule